// File: doc/BRIEF.md
# Convert Clock Prescale Auto-Selector

This block identifies which of five permitted convert-clock frequencies is driving its clock input by counting that clock's rising edges over one period of an 8 kHz master sync. Once the same frequency has been recognised in two frames in a row, it raises a lock flag, reports a rate code and starts emitting a sequencing tick at 128 kHz. That is sixteen ticks per 8 kHz sample. The selected rate also fixes the transmit-side sample timing downstream.

Both raw inputs are sampled in one fast system clock domain through two-flop synchronizers, and their rising edges are detected there. The divide ratio is chosen automatically. The 128 kHz input passes straight through, one tick per edge. Three rates use a fixed integer division. The 1.544 MHz rate uses fifteen intervals of twelve edges and a final interval of thirteen, so 193 edges give exactly sixteen ticks. Every sync rising edge restarts the tick sequence, so the ticks stay aligned to the frame.

Top module: `cclk_prescale_sel`

## Requirements
- R1: While reset is asserted and after it is released, before any frame has been classified, `locked_o` is 0, `rate_o` is 7 and `tick_o` is 0.
- R2: The rising-edge count of one frame (from one sync rise to the next) is classified as follows: 14..18 gives code 0 (128 kHz), 190..192 gives code 1 (1.536 MHz), 193..195 gives code 2 (1.544 MHz), 254..258 gives code 3 (2.048 MHz) and 318..322 gives code 4 (2.56 MHz). Any other count matches nothing. Code 7 means no rate.
- R3: `locked_o` rises only at a sync rising edge, and only when the frame just ended and the frame before it both gave the same code. The first sync edge after reset closes no frame. `rate_o` changes only at sync rising edges.
- R4: A frame whose count matches nothing clears `locked_o` and sets `rate_o` to 7. A new lock then needs two further matching frames.
- R5: When a frame matches a code different from the previous frame's code, lock is dropped. It returns only if the next frame repeats the new code.
- R6: With code 0 locked, one tick is emitted for every convert-clock rising edge.
- R7: With code 1, 3 or 4 locked, one tick is emitted for every 12, 16 or 20 edges respectively. The edge count restarts at each sync rising edge, so a frame of n edges yields floor(n/d) ticks.
- R8: With code 2 locked, ticks come after edges 12, 24, ..., 180 and then 193 of the frame. The intervals are twelve edges long except the sixteenth, which is thirteen. A 193-edge frame yields exactly 16 ticks.
- R9: No tick is emitted while `locked_o` is 0.
- R10: Each tick is a single system-clock pulse following a detected convert-clock edge.
- R11: Each input passes through a two-flop synchronizer. A rising edge is counted once however many system cycles the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cclk_i | input | 1 | Raw convert clock |
| msync_i | input | 1 | Raw 8 kHz master sync |
| tick_o | output | 1 | 128 kHz sequencing tick, one cycle wide |
| rate_o | output | 3 | Selected rate code, 7 when not locked |
| locked_o | output | 1 | Rate recognised in two consecutive frames |

## Verification
The assertions check the following on every cycle:
- lock only rises at a sync edge;
- the rate code is held between sync edges and reads 7 whenever lock is low;
- the classification windows never overlap;
- every tick follows a detected edge while locked;
- detected edges are one-cycle pulses.

Only the bench scenarios can show the rest:
- that the window boundaries (190, 192, 193, 195, 318, 322 and counts just outside) land on the right codes;
- the two-frame lock rule and its loss on a mismatch or a code change;
- the exact tick count per frame for each divide mode, including the stretched final interval at 1.544 MHz.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [2:0] {
    RATE_128K  = 3'd0,
    RATE_1M536 = 3'd1,
    RATE_1M544 = 3'd2,
    RATE_2M048 = 3'd3,
    RATE_2M560 = 3'd4,
    RATE_NONE  = 3'd7
  } rate_e;

  localparam int NUM_RATES = 5;
  localparam int MAX_LEN   = 20;

  // Nominal edges per sync frame, ordered by rate code.
  function automatic int rate_nominal(int i);
    case (i)
      0:       return 16;
      1:       return 192;
      2:       return 193;
      3:       return 256;
      default: return 320;
    endcase
  endfunction

  // Lower window bound; overlapping neighbours split at their midpoint.
  function automatic int rate_lo(int i, int tol);
    int p, c;
    c = rate_nominal(i);
    if (i == 0) return c - tol;
    p = rate_nominal(i - 1);
    if (p + tol >= c - tol) return (p + c) / 2 + 1;
    return c - tol;
  endfunction

  function automatic int rate_hi(int i, int tol);
    int c, n;
    c = rate_nominal(i);
    if (i == NUM_RATES - 1) return c + tol;
    n = rate_nominal(i + 1);
    if (c + tol >= n - tol) return (c + n) / 2;
    return c + tol;
  endfunction

  // Edges per tick interval; last marks the final interval of a frame.
  function automatic int interval_len(rate_e r, logic last);
    case (r)
      RATE_128K:  return 1;
      RATE_1M536: return 12;
      RATE_1M544: return last ? 13 : 12;
      RATE_2M048: return 16;
      RATE_2M560: return 20;
      default:    return 1;
    endcase
  endfunction

endpackage

// File: rtl/cps_sync_edge.sv
module cps_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);

  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R11
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/cps_rate_classifier.sv
module cps_rate_classifier
  import cps_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cc_rise_i,
  input  logic  ms_rise_i,
  output logic  locked_o,
  output rate_e rate_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 armed_q, armed_d;
  logic                 pvld_q, pvld_d;
  rate_e                prev_q, prev_d;
  logic                 locked_q, locked_d;
  rate_e                rate_q, rate_d;
  logic [NUM_RATES-1:0] match;
  logic                 hit;
  rate_e                cls;

  for (genvar i = 0; i < NUM_RATES; i++) begin : g_win
    localparam int LO = rate_lo(i, TOL);
    localparam int HI = rate_hi(i, TOL);
    assign match[i] = (cnt_q >= CNT_W'(LO)) && (cnt_q <= CNT_W'(HI));
  end

  always_comb begin
    cls = RATE_NONE;
    for (int i = 0; i < NUM_RATES; i++)
      if (match[i]) cls = rate_e'(i);
  end

  assign hit = |match;

  always_comb begin
    cnt_d    = cnt_q;
    armed_d  = armed_q | ms_rise_i;
    pvld_d   = pvld_q;
    prev_d   = prev_q;
    locked_d = locked_q;
    rate_d   = rate_q;
    if (ms_rise_i) begin
      cnt_d = cc_rise_i ? CNT_W'(1) : '0;
      if (armed_q) begin
        if (hit) begin
          locked_d = pvld_q && (prev_q == cls);
          rate_d   = (pvld_q && (prev_q == cls)) ? cls : RATE_NONE;
          prev_d   = cls;
          pvld_d   = 1'b1;
        end else begin
          locked_d = 1'b0;
          rate_d   = RATE_NONE;
          pvld_d   = 1'b0;
        end
      end
    end else if (cc_rise_i && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      pvld_q   <= 1'b0;
      prev_q   <= RATE_NONE;
      locked_q <= 1'b0;
      rate_q   <= RATE_NONE;
    end else begin
      cnt_q    <= cnt_d;
      armed_q  <= armed_d;
      pvld_q   <= pvld_d;
      prev_q   <= prev_d;
      locked_q <= locked_d;
      rate_q   <= rate_d;
    end
  end

  assign locked_o = locked_q;
  assign rate_o   = rate_q;

  // R2
  window_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  // R3
  lock_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(ms_rise_i));
  // R3
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_rise_i |=> $stable(rate_q));
  // R4
  none_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |-> (rate_q == RATE_NONE));

endmodule

// File: rtl/cps_tick_divider.sv
module cps_tick_divider
  import cps_pkg::*;
#(
  parameter int NTICK = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cc_rise_i,
  input  logic  ms_rise_i,
  input  logic  locked_i,
  input  rate_e rate_i,
  output logic  tick_o
);

  localparam int EW = $clog2(MAX_LEN + 1);
  localparam int IW = $clog2(NTICK);

  logic [EW-1:0] e_q, e_d, e_base, len_m1;
  logic [IW-1:0] idx_q, idx_d, idx_base;
  logic          tick_q, tick_d;
  logic          last_iv;

  always_comb begin
    e_base   = ms_rise_i ? '0 : e_q;
    idx_base = ms_rise_i ? '0 : idx_q;
    last_iv  = (idx_base == IW'(NTICK - 1));
    len_m1   = EW'(interval_len(rate_i, last_iv) - 1);
    e_d      = e_base;
    idx_d    = idx_base;
    tick_d   = 1'b0;
    if (cc_rise_i && locked_i) begin
      if (e_base == len_m1) begin
        tick_d = 1'b1;
        e_d    = '0;
        idx_d  = last_iv ? '0 : idx_base + 1'b1;
      end else begin
        e_d = e_base + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q    <= '0;
      idx_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      e_q    <= e_d;
      idx_q  <= idx_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R9
  tick_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(locked_i));
  // R10
  tick_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(cc_rise_i));
  // R10
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q || $past(cc_rise_i));

endmodule

// File: rtl/cclk_prescale_sel.sv
module cclk_prescale_sel
  import cps_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int TOL         = 2,
  parameter int NTICK       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cclk_i,
  input  logic       msync_i,
  output logic       tick_o,
  output logic [2:0] rate_o,
  output logic       locked_o
);

  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       cc_rise, ms_rise;
  logic       locked;
  rate_e      rate;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  cps_sync_edge #(.STAGES(SYNC_STAGES)) u_cc_sync (
    .clk(clk), .rst_n(rst_ni), .d_i(cclk_i), .rise_o(cc_rise)
  );

  cps_sync_edge #(.STAGES(SYNC_STAGES)) u_ms_sync (
    .clk(clk), .rst_n(rst_ni), .d_i(msync_i), .rise_o(ms_rise)
  );

  cps_rate_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
    .clk(clk), .rst_n(rst_ni), .cc_rise_i(cc_rise), .ms_rise_i(ms_rise),
    .locked_o(locked), .rate_o(rate)
  );

  cps_tick_divider #(.NTICK(NTICK)) u_div (
    .clk(clk), .rst_n(rst_ni), .cc_rise_i(cc_rise), .ms_rise_i(ms_rise),
    .locked_i(locked), .rate_i(rate), .tick_o(tick_o)
  );

  assign rate_o   = rate;
  assign locked_o = locked;

endmodule

// File: tb/sim_cclk_prescale_sel.sv
module sim_cclk_prescale_sel;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cclk_i = 1'b0;
  logic       msync_i = 1'b0;
  logic       tick_o;
  logic [2:0] rate_o;
  logic       locked_o;

  int n_checks = 0;
  int n_fail   = 0;
  int tick_total = 0;
  int wide_pulses = 0;
  logic tick_prev = 1'b0;

  typedef struct {
    logic    lk;
    int      rt;
    int      ticks;
    string   tag;
  } exp_t;
  exp_t exp_q[$];
  event ev_frame;

  // Reference model state
  logic m_armed = 1'b0, m_pvld = 1'b0, m_lock = 1'b0;
  int   m_prev = 7, m_rate = 7, m_last_n = 0;

  cclk_prescale_sel u0 (
    .clk(clk), .rst_n(rst_n), .cclk_i(cclk_i), .msync_i(msync_i),
    .tick_o(tick_o), .rate_o(rate_o), .locked_o(locked_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tick_o) tick_total++;
    if (tick_o && tick_prev) wide_pulses++;
    tick_prev = tick_o;
  end

  task automatic check(string tag, int act, int expv, string what);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic int classify(int n);
    if (n >= 14 && n <= 18)   return 0;
    if (n >= 190 && n <= 192) return 1;
    if (n >= 193 && n <= 195) return 2;
    if (n >= 254 && n <= 258) return 3;
    if (n >= 318 && n <= 322) return 4;
    return 7;
  endfunction

  function automatic int model_ticks(int r, int n);
    int e, idx, len, t;
    e = 0; idx = 0; t = 0;
    for (int k = 0; k < n; k++) begin
      case (r)
        0: len = 1;
        1: len = 12;
        2: len = (idx == 15) ? 13 : 12;
        3: len = 16;
        default: len = 20;
      endcase
      if (e == len - 1) begin
        t++; e = 0; idx = (idx == 15) ? 0 : idx + 1;
      end else e++;
    end
    return t;
  endfunction

  task automatic run_frame(int n, string tag);
    exp_t x;
    int c;
    if (m_armed) begin
      c = classify(m_last_n);
      if (c != 7) begin
        m_lock = m_pvld && (m_prev == c);
        m_rate = m_lock ? c : 7;
        m_prev = c;
        m_pvld = 1'b1;
      end else begin
        m_lock = 1'b0; m_rate = 7; m_pvld = 1'b0;
      end
    end
    m_armed = 1'b1;
    @(negedge clk) msync_i = 1'b1;
    repeat (2) @(negedge clk);
    msync_i = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      cclk_i = 1'b1;
      repeat (2) @(negedge clk);
      cclk_i = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    m_last_n = n;
    x.lk = m_lock;
    x.rt = m_rate;
    x.ticks = m_lock ? model_ticks(m_rate, n) : 0;
    x.tag = tag;
    exp_q.push_back(x);
    -> ev_frame;
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  initial begin
    int base;
    exp_t x;
    base = 0;
    forever begin
      @(ev_frame);
      x = exp_q.pop_front();
      check(x.tag, int'(locked_o), int'(x.lk), "locked");
      check(x.tag, int'(rate_o), x.rt, "rate");
      check(x.tag, tick_total - base, x.ticks, "ticks");
      base = tick_total;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1", int'(locked_o), 0, "locked in reset");
    check("R1", int'(rate_o), 7, "rate in reset");
    check("R1", int'(tick_o), 0, "tick in reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1", int'(locked_o), 0, "locked after reset");
    check("R1", int'(rate_o), 7, "rate after reset");

    run_frame(320, "R3 first frame");
    run_frame(320, "R3 R9 one frame seen");
    run_frame(320, "R3 R7 2.56 lock");
    run_frame(318, "R2 R7 low edge 2.56");
    run_frame(322, "R2 R7 high edge 2.56");
    run_frame(256, "R5 change to 2.048");
    run_frame(258, "R5 R7 2.048 relock");
    run_frame(254, "R2 R7 2.048");
    run_frame(190, "R5 change to 1.536");
    run_frame(192, "R2 R7 1.536 lock");
    run_frame(193, "R2 R7 1.536 held");
    run_frame(195, "R2 R5 1.544 change");
    run_frame(193, "R8 1.544 lock");
    run_frame(193, "R8 1.544 sixteen");
    run_frame(100, "R4 R8 unmatched next");
    run_frame(16, "R4 R9 unlocked");
    run_frame(18, "R3 R9 one match");
    run_frame(14, "R6 R11 128k direct");
    run_frame(16, "R6 R11 128k direct");
    run_frame(323, "R6 before reject");
    run_frame(189, "R4 reject 323");
    run_frame(196, "R4 reject 189");
    run_frame(5, "R4 R9 reject 196");

    check("R10", wide_pulses, 0, "tick pulses wider than one cycle");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule